// File: doc/BRIEF.md
# Stored-Program Processor Control Sequencer

This block is the control state machine for a small 8-bit processor that keeps its program in memory. The processor's datapath has four general registers, a program counter, an instruction register, an operand register Y, a one-bit registered zero flag Z and a memory address register. These are joined by two buses. Bus1 is fed by a numbered select from the general registers or the program counter. Bus2 is fed from the ALU result, from bus1 or from the memory word. The sequencer reads the instruction register contents and the registered zero flag. On every cycle it produces the register load enables, the program counter increment, both bus selects and the memory write strobe.

Each instruction begins with a two-cycle fetch and a decode cycle. Register-to-register ALU operations finish in one or two further cycles. Memory read, memory write and the two branches are two-byte instructions: the target address is the byte that follows the opcode, so they first move the program counter into the address register and then use that address. An opcode outside the defined set parks the machine in a halt state, which only reset leaves. The present state is brought out so that the sequence can be observed.

Top module: `stored_prog_ctrl`

## Requirements
- R1: A synchronous active-low reset puts the state at 0 (idle) with every control output at 0. On the first clock edge after reset is released, the state moves to 1 (fetch1).
- R2: In fetch1 (state 1) bus1 select is 4 (program counter), bus2 select is 1 (bus1) and the address register loads. In fetch2 (state 2) bus2 select is 2 (memory word), the instruction register loads and the program counter increments. Decode (state 3) follows fetch2.
- R3: The instruction word has the opcode in bits [7:4], the source index in [3:2] and the destination index in [1:0]. For ADD (1), SUB (2) and AND (3), decode drives bus1 select = source, bus2 select = 1 and loads Y. Execute (state 4) drives bus1 select = destination, bus2 select = 0 (ALU), loads the destination register and Z, and then returns to fetch1.
- R4: For NOT (4), decode itself drives bus1 select = source and bus2 select = 0, loads the destination register and Z, and returns to fetch1.
- R5: For NOP (0), decode asserts no output and returns to fetch1.
- R6: RD (5) passes through decode, then read1 (state 5), then read2 (state 6). Read1 drives bus1 select 4, bus2 select 1 and an address-register load. Read2 drives bus2 select 2, loads the destination register and increments the program counter.
- R7: WR (6) passes through decode, then write1 (state 7), then write2 (state 8). Write1 acts like read1. Write2 drives bus1 select = source, asserts the memory write strobe and increments the program counter.
- R8: BR (7) passes through decode, then branch1 (state 9), then branch2 (state 10). Branch1 acts like read1. Branch2 drives bus2 select 2 and loads the program counter; fetch1 follows.
- R9: Branch-on-zero (8) with zero flag 1 takes the BR path. With zero flag 0, decode asserts only the program counter increment and returns to fetch1.
- R10: Opcodes 9 to 15 lead from decode to halt (state 11). Decode asserts nothing for them. Halt asserts no output and stays in place whatever the inputs, until reset.
- R11: At most one of the general register loads, the program counter load, the instruction register load, the Y load and the address register load is active in any cycle. The write strobe is active only in write2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr | input | 8 | Current instruction register contents |
| zero | input | 1 | Registered zero flag Z |
| ld_gpr | output | 4 | Load enables of general registers 0 to 3 |
| ld_pc | output | 1 | Program counter load from bus2 |
| ld_ir | output | 1 | Instruction register load from bus2 |
| ld_y | output | 1 | Operand register Y load from bus2 |
| ld_z | output | 1 | Zero flag register load from the ALU |
| ld_mar | output | 1 | Memory address register load from bus2 |
| inc_pc | output | 1 | Program counter increment |
| bus1_sel | output | 3 | Bus1 source: 0 to 3 general registers, 4 program counter |
| bus2_sel | output | 2 | Bus2 source: 0 ALU, 1 bus1, 2 memory word |
| mem_wr | output | 1 | Memory write strobe |
| fsm_state | output | 4 | Present state encoding |

## Verification
Some properties are checked on every cycle of any run: the single-load rule, the write strobe being confined to write2, the fixed successors of idle, both fetch states and branch2, the read2 and branch2 outputs, and the silence and persistence of halt. The scenarios alone show the decode work that depends on the opcode. That covers the choice among the execute, read, write, branch and halt paths, the register indices taken from the instruction fields, both outcomes of branch-on-zero, and the return to idle when reset is applied during halt.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int WORD_W = 8;
    localparam int OPC_W  = 4;
    localparam int IDX_W  = 2;
    localparam int B1_W   = 3;
    localparam int B2_W   = 2;
    localparam int ST_W   = 4;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE   = 4'h0,
        ST_FETCH1 = 4'h1,
        ST_FETCH2 = 4'h2,
        ST_DECODE = 4'h3,
        ST_EXEC   = 4'h4,
        ST_READ1  = 4'h5,
        ST_READ2  = 4'h6,
        ST_WRITE1 = 4'h7,
        ST_WRITE2 = 4'h8,
        ST_BRAN1  = 4'h9,
        ST_BRAN2  = 4'hA,
        ST_HALT   = 4'hB
    } state_e;

    typedef enum logic [2:0] {
        K_NOP, K_ALU2, K_NOT, K_RD, K_WR, K_BR, K_BRZ, K_BAD
    } kind_e;

    localparam logic [B1_W-1:0] B1_PC   = 3'd4;
    localparam logic [B2_W-1:0] B2_ALU  = 2'd0;
    localparam logic [B2_W-1:0] B2_BUS1 = 2'd1;
    localparam logic [B2_W-1:0] B2_MEM  = 2'd2;

    typedef struct packed {
        logic [B1_W-1:0]  b1;
        logic [B2_W-1:0]  b2;
        logic             gpr_ld;
        logic [IDX_W-1:0] gpr_idx;
        logic             pc_ld;
        logic             ir_ld;
        logic             y_ld;
        logic             z_ld;
        logic             mar_ld;
        logic             pc_inc;
        logic             wr;
    } ctrl_t;

    typedef struct packed {
        state_e st;
    } seq_t;

endpackage

// File: rtl/spc_field_split.sv
module spc_field_split
    import spc_pkg::*;
#(
    parameter int W   = spc_pkg::WORD_W,
    parameter int OW  = spc_pkg::OPC_W,
    parameter int IW  = spc_pkg::IDX_W
) (
    input  logic [W-1:0]  instr,
    output kind_e         kind,
    output logic [IW-1:0] src,
    output logic [IW-1:0] dst
);
    logic [OW-1:0] opc;

    assign opc = instr[W-1 -: OW];
    assign src = instr[2*IW-1 -: IW];
    assign dst = instr[IW-1:0];

    always_comb begin
        case (opc)
            4'd0:                kind = K_NOP;
            4'd1, 4'd2, 4'd3:    kind = K_ALU2;
            4'd4:                kind = K_NOT;
            4'd5:                kind = K_RD;
            4'd6:                kind = K_WR;
            4'd7:                kind = K_BR;
            4'd8:                kind = K_BRZ;
            default:             kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/spc_next_state.sv
module spc_next_state
    import spc_pkg::*;
(
    input  state_e st,
    input  kind_e  kind,
    input  logic   zero,
    output state_e nxt
);
    always_comb begin
        nxt = st;
        case (st)
            ST_IDLE:   nxt = ST_FETCH1;
            ST_FETCH1: nxt = ST_FETCH2;
            ST_FETCH2: nxt = ST_DECODE;
            ST_DECODE: begin
                case (kind)
                    K_ALU2:  nxt = ST_EXEC;
                    K_RD:    nxt = ST_READ1;
                    K_WR:    nxt = ST_WRITE1;
                    K_BR:    nxt = ST_BRAN1;
                    K_BRZ:   nxt = zero ? ST_BRAN1 : ST_FETCH1;
                    K_BAD:   nxt = ST_HALT;
                    default: nxt = ST_FETCH1;
                endcase
            end
            ST_READ1:  nxt = ST_READ2;
            ST_WRITE1: nxt = ST_WRITE2;
            ST_BRAN1:  nxt = ST_BRAN2;
            ST_EXEC, ST_READ2, ST_WRITE2, ST_BRAN2: nxt = ST_FETCH1;
            ST_HALT:   nxt = ST_HALT;
            default:   nxt = ST_HALT;
        endcase
    end
endmodule

// File: rtl/spc_ctrl_out.sv
module spc_ctrl_out
    import spc_pkg::*;
(
    input  state_e           st,
    input  kind_e            kind,
    input  logic [IDX_W-1:0] src,
    input  logic [IDX_W-1:0] dst,
    input  logic             zero,
    output ctrl_t            c
);
    always_comb begin
        c = '0;
        case (st)
            ST_FETCH1, ST_READ1, ST_WRITE1, ST_BRAN1: begin
                c.b1     = B1_PC;
                c.b2     = B2_BUS1;
                c.mar_ld = 1'b1;
            end
            ST_FETCH2: begin
                c.b2     = B2_MEM;
                c.ir_ld  = 1'b1;
                c.pc_inc = 1'b1;
            end
            ST_DECODE: begin
                case (kind)
                    K_ALU2: begin
                        c.b1   = B1_W'(src);
                        c.b2   = B2_BUS1;
                        c.y_ld = 1'b1;
                    end
                    K_NOT: begin
                        c.b1      = B1_W'(src);
                        c.b2      = B2_ALU;
                        c.gpr_ld  = 1'b1;
                        c.gpr_idx = dst;
                        c.z_ld    = 1'b1;
                    end
                    K_BRZ:   c.pc_inc = ~zero;
                    default: c = '0;
                endcase
            end
            ST_EXEC: begin
                c.b1      = B1_W'(dst);
                c.b2      = B2_ALU;
                c.gpr_ld  = 1'b1;
                c.gpr_idx = dst;
                c.z_ld    = 1'b1;
            end
            ST_READ2: begin
                c.b2      = B2_MEM;
                c.gpr_ld  = 1'b1;
                c.gpr_idx = dst;
                c.pc_inc  = 1'b1;
            end
            ST_WRITE2: begin
                c.b1     = B1_W'(src);
                c.wr     = 1'b1;
                c.pc_inc = 1'b1;
            end
            ST_BRAN2: begin
                c.b2    = B2_MEM;
                c.pc_ld = 1'b1;
            end
            default: c = '0;
        endcase
    end
endmodule

// File: rtl/stored_prog_ctrl.sv
module stored_prog_ctrl
    import spc_pkg::*;
#(
    parameter int WORD_W = spc_pkg::WORD_W,
    parameter int IDX_W  = spc_pkg::IDX_W,
    parameter int B1_W   = spc_pkg::B1_W,
    parameter int B2_W   = spc_pkg::B2_W,
    parameter int ST_W   = spc_pkg::ST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] instr,
    input  logic              zero,
    output logic [(1<<IDX_W)-1:0] ld_gpr,
    output logic              ld_pc,
    output logic              ld_ir,
    output logic              ld_y,
    output logic              ld_z,
    output logic              ld_mar,
    output logic              inc_pc,
    output logic [B1_W-1:0]   bus1_sel,
    output logic [B2_W-1:0]   bus2_sel,
    output logic              mem_wr,
    output logic [ST_W-1:0]   fsm_state
);
    localparam int NUM_GPR = 1 << IDX_W;

    seq_t              seq_d, seq_q;
    state_e            nxt_st;
    kind_e             kind;
    logic [IDX_W-1:0]  src_idx, dst_idx;
    ctrl_t             ctl;

    spc_field_split #(.W(WORD_W), .OW(spc_pkg::OPC_W), .IW(IDX_W)) i_split (
        .instr (instr),
        .kind  (kind),
        .src   (src_idx),
        .dst   (dst_idx)
    );

    spc_next_state i_next (
        .st   (seq_q.st),
        .kind (kind),
        .zero (zero),
        .nxt  (nxt_st)
    );

    spc_ctrl_out i_out (
        .st   (seq_q.st),
        .kind (kind),
        .src  (src_idx),
        .dst  (dst_idx),
        .zero (zero),
        .c    (ctl)
    );

    always_comb begin
        seq_d    = seq_q;
        seq_d.st = nxt_st;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr_ld
        assign ld_gpr[g] = ctl.gpr_ld && (ctl.gpr_idx == IDX_W'(g));
    end

    assign ld_pc     = ctl.pc_ld;
    assign ld_ir     = ctl.ir_ld;
    assign ld_y      = ctl.y_ld;
    assign ld_z      = ctl.z_ld;
    assign ld_mar    = ctl.mar_ld;
    assign inc_pc    = ctl.pc_inc;
    assign bus1_sel  = ctl.b1;
    assign bus2_sel  = ctl.b2;
    assign mem_wr    = ctl.wr;
    assign fsm_state = seq_q.st;

endmodule

// File: rtl/spc_ctrl_chk.sv
module spc_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] instr,
    input logic       zero,
    input logic [3:0] ld_gpr,
    input logic       ld_pc,
    input logic       ld_ir,
    input logic       ld_y,
    input logic       ld_z,
    input logic       ld_mar,
    input logic       inc_pc,
    input logic [2:0] bus1_sel,
    input logic [1:0] bus2_sel,
    input logic       mem_wr,
    input logic [3:0] fsm_state
);
    // R11
    one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ld_gpr, ld_pc, ld_ir, ld_y, ld_mar}) <= 1);

    // R11
    wr_in_write2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> fsm_state == 4'h8);

    // R1
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == 4'h0 |=> fsm_state == 4'h1);

    // R2
    fetch1_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == 4'h1 |=> fsm_state == 4'h2);

    // R2
    fetch2_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == 4'h2 |=> fsm_state == 4'h3);

    // R6
    read2_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == 4'h6 |-> inc_pc && bus2_sel == 2'd2 && $onehot0(ld_gpr) && ld_gpr != 4'h0);

    // R8
    branch2_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == 4'hA |-> ld_pc && bus2_sel == 2'd2);

    // R8
    branch2_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == 4'hA |=> fsm_state == 4'h1);

    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == 4'hB |=> fsm_state == 4'hB);

    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == 4'hB |-> {ld_gpr, ld_pc, ld_ir, ld_y, ld_z, ld_mar, inc_pc, mem_wr} == '0);
endmodule

bind stored_prog_ctrl spc_ctrl_chk i_spc_ctrl_chk (.*);

// File: tb/test_stored_prog_ctrl.sv
module test_stored_prog_ctrl;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WDOG_CYC   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] instr = 8'h00;
    logic       zero = 1'b0;
    logic [3:0] ld_gpr;
    logic       ld_pc, ld_ir, ld_y, ld_z, ld_mar, inc_pc, mem_wr;
    logic [2:0] bus1_sel;
    logic [1:0] bus2_sel;
    logic [3:0] fsm_state;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stored_prog_ctrl i_stored_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .instr(instr), .zero(zero),
        .ld_gpr(ld_gpr), .ld_pc(ld_pc), .ld_ir(ld_ir), .ld_y(ld_y),
        .ld_z(ld_z), .ld_mar(ld_mar), .inc_pc(inc_pc),
        .bus1_sel(bus1_sel), .bus2_sel(bus2_sel), .mem_wr(mem_wr),
        .fsm_state(fsm_state)
    );

    function automatic logic [19:0] ev(logic [3:0] st, logic [2:0] b1, logic [1:0] b2,
                                       logic [3:0] g, logic pcl, logic irl, logic yl,
                                       logic zl, logic marl, logic inc, logic wr);
        return {st, b1, b2, g, pcl, irl, yl, zl, marl, inc, wr};
    endfunction

    task automatic chk(input logic [19:0] exp, input string tag);
        logic [19:0] obs;
        obs = {fsm_state, bus1_sel, bus2_sel, ld_gpr, ld_pc, ld_ir, ld_y, ld_z,
               ld_mar, inc_pc, mem_wr};
        n_chk++;
        if (obs !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, obs, exp);
        end
    endtask

    task automatic adv();
        @(negedge clk);
        #1;
    endtask

    localparam logic [19:0] QUIET = 20'h0;

    task automatic t_reset();
        rst_n = 1'b0;
        adv();
        adv();
        chk(ev(4'h0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R1 idle under reset");
        rst_n = 1'b1;
        #1;
        chk(ev(4'h0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R1 idle before first edge");
        adv();
        chk(ev(4'h1, 3'd4, 2'd1, 0, 0, 0, 0, 0, 1, 0, 0), "R1 fetch1 after release");
    endtask

    task automatic t_fetch(input logic [7:0] w, input logic z);
        chk(ev(4'h1, 3'd4, 2'd1, 0, 0, 0, 0, 0, 1, 0, 0), "R2 fetch1");
        adv();
        chk(ev(4'h2, 3'd0, 2'd2, 0, 0, 1, 0, 0, 0, 1, 0), "R2 fetch2");
        instr = w;
        zero  = z;
        adv();
    endtask

    task automatic t_alu(input logic [3:0] op, input logic [1:0] s, input logic [1:0] d);
        t_fetch({op, s, d}, 1'b0);
        chk(ev(4'h3, {1'b0, s}, 2'd1, 0, 0, 0, 1, 0, 0, 0, 0), "R3 decode");
        adv();
        chk(ev(4'h4, {1'b0, d}, 2'd0, 4'b1 << d, 0, 0, 0, 1, 0, 0, 0), "R3 execute");
        adv();
    endtask

    task automatic t_not(input logic [1:0] s, input logic [1:0] d);
        t_fetch({4'h4, s, d}, 1'b1);
        chk(ev(4'h3, {1'b0, s}, 2'd0, 4'b1 << d, 0, 0, 0, 1, 0, 0, 0), "R4 decode");
        adv();
    endtask

    task automatic t_nop();
        t_fetch(8'h0F, 1'b1);
        chk(ev(4'h3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R5 decode");
        adv();
    endtask

    task automatic t_rd(input logic [1:0] d);
        t_fetch({4'h5, 2'b11, d}, 1'b0);
        chk(ev(4'h3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R6 decode");
        adv();
        chk(ev(4'h5, 3'd4, 2'd1, 0, 0, 0, 0, 0, 1, 0, 0), "R6 read1");
        adv();
        chk(ev(4'h6, 3'd0, 2'd2, 4'b1 << d, 0, 0, 0, 0, 0, 1, 0), "R6 read2");
        adv();
    endtask

    task automatic t_wr(input logic [1:0] s);
        t_fetch({4'h6, s, 2'b00}, 1'b0);
        chk(ev(4'h3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R7 decode");
        adv();
        chk(ev(4'h7, 3'd4, 2'd1, 0, 0, 0, 0, 0, 1, 0, 0), "R7 write1");
        adv();
        chk(ev(4'h8, {1'b0, s}, 2'd0, 0, 0, 0, 0, 0, 0, 1, 1), "R7 R11 write2");
        adv();
    endtask

    task automatic t_br(input logic [3:0] op, input string tag);
        t_fetch({op, 4'h0}, 1'b1);
        chk(ev(4'h3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), tag);
        adv();
        chk(ev(4'h9, 3'd4, 2'd1, 0, 0, 0, 0, 0, 1, 0, 0), tag);
        adv();
        chk(ev(4'hA, 3'd0, 2'd2, 0, 1, 0, 0, 0, 0, 0, 0), tag);
        adv();
    endtask

    task automatic t_brz_skip();
        t_fetch(8'h80, 1'b0);
        chk(ev(4'h3, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0), "R9 not taken decode");
        adv();
        chk(ev(4'h1, 3'd4, 2'd1, 0, 0, 0, 0, 0, 1, 0, 0), "R9 back to fetch1");
    endtask

    task automatic t_bad(input logic [3:0] op);
        t_fetch({op, 4'h5}, 1'b0);
        chk(ev(4'h3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R10 decode illegal");
        adv();
        for (int k = 0; k < 4; k++) begin
            chk(ev(4'hB, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R10 halt held");
            instr = {4'h1, 2'(k), 2'(3 - k)};
            zero  = ~zero;
            adv();
        end
        t_reset();
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_alu(4'h1, 2'd2, 2'd1);
        t_alu(4'h2, 2'd0, 2'd3);
        t_alu(4'h3, 2'd3, 2'd0);
        t_not(2'd1, 2'd2);
        t_nop();
        t_rd(2'd0);
        t_rd(2'd3);
        t_wr(2'd2);
        t_br(4'h7, "R8 branch");
        t_br(4'h8, "R9 taken branch");
        t_brz_skip();
        t_bad(4'h9);
        t_bad(4'hF);
        t_alu(4'h1, 2'd1, 2'd1);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule